// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, cycle by cycle, which hardware thread of a multithreaded front end gets the fetch slot. Each thread reports a three-bit fetch state and an active bit, and the back end reports two occupancy counts per thread, one for the issue queue and one for the load/store queue. A three-bit policy code chooses how the winner is found. The result is a thread index plus a valid flag, and both are combinational from the current inputs and the stored rotation order.

The only state is a rotation order, which holds each thread index exactly once. It is used only by the rotating policy. In that policy the order is walked from its head, the first thread that is allowed to fetch wins, and that thread moves to the tail. The fixed single-thread policy ignores thread states entirely. Every pin is a plain control or status level. There is no data stream, so there is no valid/ready handshake and no back-pressure. A build with one thread grants that thread only when its state permits fetch.

Top module: `fetch_thread_sel`

## Requirements
- R1: The policy code is 0 for fixed single-thread, 1 for rotating, 2 for branch-count, 3 for issue-queue count and 4 for load/store-queue count. The thread state codes are 0 run, 1 idle, 2 miss-returned, 3 held, 4 flushing, 5 miss-waiting, 6 trap-waiting and 7 sleeping. Thread t's state sits in bits [3t+2:3t].
- R2: A thread may fetch only if its active bit is set and its state is run, idle or miss-returned. In the rotating and occupancy policies, only threads that may fetch are granted.
- R3: In the rotating policy, the grant goes to the first thread in the rotation order, counted from the head, that may fetch.
- R4: After a rotating grant, the granted thread moves to the tail of the order. All other threads keep their relative order.
- R5: When no thread may fetch in the rotating or occupancy policies, the valid flag is low. In the rotating policy the order is then left unchanged.
- R6: After reset the rotation order is ascending thread index, with thread 0 at the head.
- R7: The rotation order changes only on a clock edge where the rotating policy gives a grant.
- R8: In the fixed single-thread policy, thread 0 is granted with valid high, whatever the states and active bits are.
- R9: The issue-queue policy grants the thread with the smallest issue-queue count among those that may fetch. The load/store-queue policy does the same with load/store-queue counts. Ties go to the lower index.
- R10: The branch-count policy grants the lowest-index active thread, regardless of state. If no thread is active, valid is low.
- R11: Policy codes 5 to 7 give no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the rotation order |
| mode_i | input | 3 | Policy code |
| active_i | input | NT | Per-thread active bits |
| status_i | input | 3*NT | Per-thread state codes |
| iq_occ_i | input | OCC_W*NT | Per-thread issue-queue counts |
| lsq_occ_i | input | OCC_W*NT | Per-thread load/store-queue counts |
| grant_valid_o | output | 1 | A thread is granted |
| grant_tid_o | output | TID_W | Granted thread index |

## Verification
The hardest case to reach from the ports is a rotation order that is no longer a simple rotation of ascending indices. That only happens when a thread is passed over while it cannot fetch and then becomes eligible again. The stimulus holds thread 1 in the held state while two other threads win rotating grants, then releases it and expects thread 1 to win at once. Next it runs the occupancy policies and a cycle with no eligible thread, and checks that the next rotating grants continue from exactly the order that was left behind.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  typedef enum logic [2:0] {
    ST_RUN = 3'd0, ST_IDLE = 3'd1, ST_FILL_DONE = 3'd2, ST_HOLD = 3'd3,
    ST_FLUSH = 3'd4, ST_FILL_WAIT = 3'd5, ST_TRAP = 3'd6, ST_SLEEP = 3'd7
  } fstat_e;

  typedef enum logic [2:0] {
    POL_SOLO = 3'd0, POL_ROTATE = 3'd1, POL_BRCNT = 3'd2,
    POL_IQ = 3'd3, POL_LSQ = 3'd4
  } fpol_e;

  function automatic logic stat_ok(input logic [2:0] s);
    return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FILL_DONE);
  endfunction
endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
  import fsel_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [NT-1:0]   active_i,
  input  logic [3*NT-1:0] status_i,
  output logic [NT-1:0]   elig_o
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign elig_o[t] = active_i[t] & stat_ok(status_i[3*t +: 3]);
  end
endmodule

// File: rtl/fsel_rr.sv
module fsel_rr #(
  parameter int NT    = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    elig_i,
  input  logic             advance_i,
  output logic             pick_valid_o,
  output logic [TID_W-1:0] pick_tid_o
);
  logic [TID_W-1:0] order_q [NT];
  logic [TID_W-1:0] order_n [NT];
  int unsigned      pick_pos;

  always_comb begin
    pick_valid_o = 1'b0;
    pick_tid_o   = '0;
    pick_pos     = 0;
    for (int p = 0; p < NT; p++) begin
      if (!pick_valid_o && elig_i[order_q[p]]) begin
        pick_valid_o = 1'b1;
        pick_tid_o   = order_q[p];
        pick_pos     = p;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NT; p++) begin
      if (p < pick_pos)    order_n[p] = order_q[p];
      else if (p < NT - 1) order_n[p] = order_q[p+1];
      else                 order_n[p] = pick_tid_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NT; p++) order_q[p] <= TID_W'(p);
    end else if (advance_i && pick_valid_o) begin
      for (int p = 0; p < NT; p++) order_q[p] <= order_n[p];
    end
  end
endmodule

// File: rtl/fsel_minsel.sv
module fsel_minsel #(
  parameter int NT    = 4,
  parameter int OCC_W = 6,
  parameter int TID_W = 2
) (
  input  logic [NT-1:0]       elig_i,
  input  logic [OCC_W*NT-1:0] occ_i,
  output logic                valid_o,
  output logic [TID_W-1:0]    tid_o
);
  logic [OCC_W-1:0] best;

  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    best    = '0;
    for (int t = 0; t < NT; t++) begin
      if (elig_i[t] && (!valid_o || occ_i[OCC_W*t +: OCC_W] < best)) begin
        valid_o = 1'b1;
        tid_o   = TID_W'(t);
        best    = occ_i[OCC_W*t +: OCC_W];
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fsel_pkg::*;
#(
  parameter int NT    = 4,
  parameter int OCC_W = 6,
  parameter int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_i,
  input  logic [NT-1:0]       active_i,
  input  logic [3*NT-1:0]     status_i,
  input  logic [OCC_W*NT-1:0] iq_occ_i,
  input  logic [OCC_W*NT-1:0] lsq_occ_i,
  output logic                grant_valid_o,
  output logic [TID_W-1:0]    grant_tid_o
);
  logic [NT-1:0]       elig;
  logic                rr_valid, min_valid, br_valid;
  logic [TID_W-1:0]    rr_tid, min_tid, br_tid;
  logic [OCC_W*NT-1:0] occ_sel;

  fsel_elig #(.NT(NT)) u_elig (
    .active_i(active_i), .status_i(status_i), .elig_o(elig)
  );

  fsel_rr #(.NT(NT), .TID_W(TID_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .elig_i(elig),
    .advance_i(mode_i == POL_ROTATE),
    .pick_valid_o(rr_valid), .pick_tid_o(rr_tid)
  );

  assign occ_sel = (mode_i == POL_LSQ) ? lsq_occ_i : iq_occ_i;

  fsel_minsel #(.NT(NT), .OCC_W(OCC_W), .TID_W(TID_W)) u_min (
    .elig_i(elig), .occ_i(occ_sel), .valid_o(min_valid), .tid_o(min_tid)
  );

  always_comb begin
    br_valid = 1'b0;
    br_tid   = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (active_i[t]) begin
        br_valid = 1'b1;
        br_tid   = TID_W'(t);
      end
    end
  end

  if (NT == 1) begin : g_one
    assign grant_valid_o = elig[0];
    assign grant_tid_o   = '0;
  end else begin : g_multi
    always_comb begin
      grant_valid_o = 1'b0;
      grant_tid_o   = '0;
      case (mode_i)
        POL_SOLO:       begin grant_valid_o = 1'b1; grant_tid_o = '0; end
        POL_ROTATE:     begin grant_valid_o = rr_valid;  grant_tid_o = rr_tid;  end
        POL_BRCNT:      begin grant_valid_o = br_valid;  grant_tid_o = br_tid;  end
        POL_IQ, POL_LSQ: begin grant_valid_o = min_valid; grant_tid_o = min_tid; end
        default:        begin grant_valid_o = 1'b0; grant_tid_o = '0; end
      endcase
    end
  end
endmodule

// File: rtl/fsel_chk.sv
module fsel_chk
  import fsel_pkg::*;
#(
  parameter int NT    = 4,
  parameter int OCC_W = 6,
  parameter int TID_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          mode_i,
  input logic [NT-1:0]       active_i,
  input logic [3*NT-1:0]     status_i,
  input logic [OCC_W*NT-1:0] iq_occ_i,
  input logic [OCC_W*NT-1:0] lsq_occ_i,
  input logic                grant_valid_o,
  input logic [TID_W-1:0]    grant_tid_o
);
  logic [NT-1:0]       ok;
  logic [OCC_W*NT-1:0] occ;
  logic                better;
  logic                gated;

  always_comb begin
    for (int t = 0; t < NT; t++) ok[t] = active_i[t] & stat_ok(status_i[3*t +: 3]);
  end

  assign occ   = (mode_i == POL_LSQ) ? lsq_occ_i : iq_occ_i;
  assign gated = (mode_i == POL_ROTATE) || (mode_i == POL_IQ) || (mode_i == POL_LSQ);

  always_comb begin
    better = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (ok[t] && ((occ[OCC_W*t +: OCC_W] < occ[OCC_W*grant_tid_o +: OCC_W]) ||
          ((occ[OCC_W*t +: OCC_W] == occ[OCC_W*grant_tid_o +: OCC_W]) && (TID_W'(t) < grant_tid_o))))
        better = 1'b1;
    end
  end

  a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    gated && grant_valid_o |-> ok[grant_tid_o]);
  a_r5_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    gated && (ok == '0) |-> !grant_valid_o);
  a_r8_solo_thread0: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == POL_SOLO) |-> grant_valid_o && (grant_tid_o == '0));
  a_r9_min_occ: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == POL_IQ) || (mode_i == POL_LSQ)) && grant_valid_o |-> !better);
  a_r4_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == POL_ROTATE) && grant_valid_o && ($countones(ok) > 1) ##1
    (mode_i == POL_ROTATE) && (ok == $past(ok)) |-> grant_tid_o != $past(grant_tid_o));
  a_r10_branch_active: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == POL_BRCNT) && (active_i != '0) |-> grant_valid_o && active_i[grant_tid_o]);
  a_r11_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > 3'd4) |-> !grant_valid_o);
endmodule

bind fetch_thread_sel fsel_chk #(.NT(NT), .OCC_W(OCC_W), .TID_W(TID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .active_i(active_i),
  .status_i(status_i), .iq_occ_i(iq_occ_i), .lsq_occ_i(lsq_occ_i),
  .grant_valid_o(grant_valid_o), .grant_tid_o(grant_tid_o)
);

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb_top;
  localparam int NT = 4, OCC_W = 6, TID_W = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2:0]          mode;
  logic [NT-1:0]       active;
  logic [3*NT-1:0]     status;
  logic [OCC_W*NT-1:0] iq_occ, lsq_occ;
  logic                gv;
  logic [TID_W-1:0]    gt;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fetch_thread_sel #(.NT(NT), .OCC_W(OCC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .active_i(active),
    .status_i(status), .iq_occ_i(iq_occ), .lsq_occ_i(lsq_occ),
    .grant_valid_o(gv), .grant_tid_o(gt)
  );

  function automatic logic [11:0] st(input int s3, s2, s1, s0);
    return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
  endfunction

  function automatic logic [23:0] oc(input int o3, o2, o1, o0);
    return {6'(o3), 6'(o2), 6'(o1), 6'(o0)};
  endfunction

  // drive at negedge, compare 2 ns later, then move through one posedge
  task automatic step(input logic [2:0] m, input logic [3:0] a, input logic [11:0] s,
                      input logic ev, input int et, input string req);
    mode = m; active = a; status = s;
    #2;
    checks++;
    if (gv !== ev || (ev && gt !== TID_W'(et))) begin
      errors++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d", req, gv, gt, ev, et);
    end
    @(negedge clk);
  endtask

  task automatic t_reset_rotate;
    // R6 reset order 0,1,2,3; R3/R4 plain rotation
    step(3'd1, 4'hF, st(0,0,0,0), 1, 0, "R6");
    step(3'd1, 4'hF, st(0,0,0,0), 1, 1, "R3");
    step(3'd1, 4'hF, st(0,0,0,0), 1, 2, "R3");
    step(3'd1, 4'hF, st(0,0,0,0), 1, 3, "R3");
    step(3'd1, 4'hF, st(0,0,0,0), 1, 0, "R4");
  endtask

  task automatic t_skip;
    // order [1,2,3,0]; thread 1 held (3) is passed over and stays at head
    step(3'd1, 4'hF, st(0,0,3,0), 1, 2, "R3");
    step(3'd1, 4'hF, st(0,0,3,0), 1, 3, "R3");
    step(3'd1, 4'hF, st(0,0,0,0), 1, 1, "R4");
  endtask

  task automatic t_freeze;
    // order [0,2,3,1]; non-rotating cycles and an empty rotating cycle leave it
    iq_occ = oc(0,0,0,0); lsq_occ = oc(0,0,0,0);
    step(3'd3, 4'hF, st(0,0,0,0), 1, 0, "R7");
    step(3'd2, 4'hF, st(0,0,0,0), 1, 0, "R7");
    step(3'd1, 4'hF, st(3,3,3,3), 0, 0, "R5");
    step(3'd1, 4'h0, st(0,0,0,0), 0, 0, "R5");
    step(3'd1, 4'hF, st(0,0,0,0), 1, 0, "R7");
    step(3'd1, 4'hF, st(0,0,0,0), 1, 2, "R4");
  endtask

  task automatic t_states;
    // IQ policy with equal counts: lowest eligible index wins (R2)
    iq_occ = oc(0,0,0,0);
    for (int s = 0; s < 8; s++) begin
      step(3'd3, 4'hF, st(0,0,0,s), 1, (s <= 2) ? 0 : 1, "R2");
    end
    step(3'd3, 4'hE, st(0,0,0,0), 1, 1, "R2");
  endtask

  task automatic t_occ;
    iq_occ = oc(9,3,3,5); lsq_occ = oc(1,7,2,8);
    step(3'd3, 4'hF, st(0,0,0,0), 1, 1, "R9");
    step(3'd3, 4'hF, st(0,0,4,0), 1, 2, "R9");
    step(3'd4, 4'hF, st(0,0,0,0), 1, 3, "R9");
    step(3'd4, 4'h7, st(0,0,0,0), 1, 1, "R9");
    step(3'd4, 4'hF, st(7,6,5,4), 0, 0, "R5");
  endtask

  task automatic t_fixed;
    step(3'd0, 4'h0, st(3,3,3,3), 1, 0, "R8");
    step(3'd0, 4'hE, st(0,0,0,0), 1, 0, "R8");
    step(3'd2, 4'hC, st(3,3,3,3), 1, 2, "R10");
    step(3'd2, 4'h0, st(0,0,0,0), 0, 0, "R10");
    step(3'd5, 4'hF, st(0,0,0,0), 0, 0, "R11");
    step(3'd7, 4'hF, st(0,0,0,0), 0, 0, "R11");
    // order after t_freeze is [3,1,0,2]; codes above must not have moved it (R1 codes)
    step(3'd1, 4'hF, st(0,0,0,0), 1, 3, "R1");
  endtask

  initial begin
    mode = 3'd1; active = '0; status = '0; iq_occ = '0; lsq_occ = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_rotate();
    t_skip();
    t_freeze();
    t_states();
    t_occ();
    t_fixed();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule